// File: doc/BRIEF.md
# Branch and Call Sequencer

This block works out the next program counter for the jump-class instructions of a 64-bit register virtual machine. Each cycle the instruction issue stage presents the current PC, the 8-bit opcode, the 4-bit source-register field, the 16-bit offset, the 32-bit immediate, the two register values and a flag saying whether the current instruction is a wide one. The block then decides the outcome. This can be a conditional branch compared on 64 or 32 bits, an unconditional jump, a call to a host helper routine, a call to a local subroutine, or an exit.

The PC counts 64-bit instruction slots. Every displacement is relative to the slot after the current instruction. An internal return-address stack records where each local call must return to. An exit pops that stack, or it signals the host that the program has finished when the stack is empty. Illegal encodings and stack overflow raise a fault and hold the PC where it was.

Each result is registered and appears one clock after the instruction was presented. Instruction fetch, wide-instruction length detection and helper execution belong to the surrounding pipeline.

Top module: `bcs_branch_seq`

## Requirements
- R1: After reset, `out_valid`, `br_taken`, `prog_done`, `helper_req`, `helper_by_type` and `fault` are 0, and `next_pc` and `helper_id` are 0.
- R2: A result appears exactly one clock after a cycle with `in_valid` high, with `out_valid` high. A cycle without `in_valid` gives `out_valid` low on the next clock.
- R3: For class 3'h5 (`opcode[2:0]`), condition codes (`opcode[7:4]`) 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 AND nonzero, 5 not equal, 6 signed greater, 7 signed greater-or-equal, 4'ha unsigned less, 4'hb unsigned less-or-equal, 4'hc signed less and 4'hd signed less-or-equal compare all 64 bits of `dst_val`. The second operand is `src_val` when `opcode[3]` is 1, or the immediate sign-extended to 64 bits when it is 0. When the condition holds, `br_taken`=1 and `next_pc` = next slot + sign-extended `offset`. Otherwise `br_taken`=0 and `next_pc` = next slot.
- R4: For class 3'h6, the same conditions compare only bits 31:0 of both operands. The signed codes treat bit 31 as the sign.
- R5: The next slot is `cur_pc`+1, or `cur_pc`+2 when `is_wide` is 1. PC arithmetic wraps modulo 2^PC_W.
- R6: Code 0 with `opcode[3]`=0 is an unconditional jump with `br_taken`=1. Its target is next slot + sign-extended `offset` in class 3'h5, and next slot + sign-extended immediate in class 3'h6.
- R7: Code 8 in class 3'h5 with `opcode[3]`=0 and `src_sel` 0 or 2 is a helper request. It gives `helper_req`=1, `helper_id`=immediate, `helper_by_type`=1 only for `src_sel` 2, `br_taken`=0 and `next_pc` = next slot. For every other result, `helper_id` and `helper_by_type` are 0.
- R8: Code 8 in class 3'h5 with `opcode[3]`=0 and `src_sel` 1 is a local call. It pushes the next slot, sets `br_taken`=1, and sets `next_pc` = next slot + sign-extended immediate.
- R9: Code 9 in class 3'h5 with `opcode[3]`=0 and `src_sel` 0 is an exit. With the stack non-empty, it pops the most recently pushed address into `next_pc` with `br_taken`=1 (last in, first out).
- R10: An exit with an empty stack gives `prog_done`=1, `br_taken`=0 and `next_pc` = `cur_pc`.
- R11: The stack holds RS_DEPTH (8) addresses. A local call with the stack full gives `fault`=1 and `next_pc` = `cur_pc`, and leaves the stack contents unchanged.
- R12: The following encodings are illegal: a class other than 3'h5 or 3'h6, codes 4'he and 4'hf, code 0 with `opcode[3]`=1, code 8 or 9 in class 3'h6 or with `opcode[3]`=1, code 8 with `src_sel` above 2, and code 9 with nonzero `src_sel`. An illegal encoding gives `fault`=1, `next_pc` = `cur_pc` and all other flags 0, and it does not touch the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| cur_pc | input | PC_W | Slot address of the current instruction |
| opcode | input | 8 | Operation byte: code, source select, class |
| src_sel | input | 4 | Source-register field (call subtype) |
| offset | input | 16 | Signed displacement field |
| imm | input | 32 | Immediate field |
| dst_val | input | 64 | First comparison operand |
| src_val | input | 64 | Register second operand |
| is_wide | input | 1 | Current instruction occupies two slots |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Computed next PC |
| br_taken | output | 1 | Control flow left the sequential path |
| prog_done | output | 1 | Program finished, return to host |
| helper_req | output | 1 | Host helper call requested |
| helper_by_type | output | 1 | Helper is named by type ID rather than static ID |
| helper_id | output | 32 | Helper identifier |
| fault | output | 1 | Illegal encoding or stack overflow |

## Verification
All eleven condition codes run in both classes against an operand pair whose top bit is set. That pair separates unsigned from signed ordering. A second pair differs only above bit 31, which separates the 64-bit class from the 32-bit class. A compare of all-ones against an immediate of -1 shows whether the immediate is sign-extended, and wide versus normal instructions show whether the next-slot step is right. Nested calls followed by exits check the last-in-first-out return order. Filling the stack and then making one more call checks the overflow fault, and the exits that follow show the stored addresses survived. Each illegal form is placed between a call and its exit, so any corruption of the stack shows up at the ports.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned DATA_W = 64;
  localparam logic [2:0] CLS_J64 = 3'h5;
  localparam logic [2:0] CLS_J32 = 3'h6;
  localparam logic [3:0] CODE_JA   = 4'h0;
  localparam logic [3:0] CODE_CALL = 4'h8;
  localparam logic [3:0] CODE_EXIT = 4'h9;

  typedef enum logic [2:0] {
    K_COND, K_JA, K_HELPER, K_LCALL, K_EXIT, K_BAD
  } op_kind_e;

  function automatic logic [DATA_W-1:0] sx16(input logic [15:0] v);
    return {{(DATA_W-16){v[15]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] sx32(input logic [31:0] v);
    return {{(DATA_W-32){v[31]}}, v};
  endfunction

  function automatic logic cond_legal(input logic [3:0] code);
    return (code >= 4'h1 && code <= 4'h7) || (code >= 4'ha && code <= 4'hd);
  endfunction

  // ua/ub are zero-widened operands, sa/sb sign-widened ones
  function automatic logic cond_hit(input logic [3:0] code,
                                    input logic [DATA_W-1:0] ua, input logic [DATA_W-1:0] ub,
                                    input logic [DATA_W-1:0] sa, input logic [DATA_W-1:0] sb);
    case (code)
      4'h1: return ua == ub;
      4'h2: return ua > ub;
      4'h3: return ua >= ub;
      4'h4: return |(ua & ub);
      4'h5: return ua != ub;
      4'h6: return $signed(sa) > $signed(sb);
      4'h7: return $signed(sa) >= $signed(sb);
      4'ha: return ua < ub;
      4'hb: return ua <= ub;
      4'hc: return $signed(sa) < $signed(sb);
      4'hd: return $signed(sa) <= $signed(sb);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_cond_eval.sv
module bcs_cond_eval
  import bcs_pkg::*;
(
  input  logic [3:0]        code,
  input  logic              narrow,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              hit,
  output logic              legal
);
  logic [DATA_W-1:0] ua, ub, sa, sb;

  // R4: the 32-bit class looks at the low half only
  always_comb begin
    if (narrow) begin
      ua = {32'b0, dst_val[31:0]};
      ub = {32'b0, opnd_b[31:0]};
      sa = sx32(dst_val[31:0]);
      sb = sx32(opnd_b[31:0]);
    end else begin
      ua = dst_val;
      ub = opnd_b;
      sa = dst_val;
      sb = opnd_b;
    end
  end

  assign hit   = cond_hit(code, ua, ub, sa, sb);
  assign legal = cond_legal(code);

  always_comb begin
    assert_hit_needs_legal_R12: assert (!hit || legal);
  end
endmodule

// File: rtl/bcs_ret_stack.sv
module bcs_ret_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_pc,
  output logic [W-1:0] top_pc,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;

  assign cnt_m1 = cnt - CNT_ONE;
  assign full   = (cnt == CNT_MAX);
  assign empty  = (cnt == '0);
  assign top_pc = slots[cnt_m1[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push) begin
      slots[cnt[PTR_W-1:0]] <= push_pc;
      cnt <= cnt + CNT_ONE;
    end else if (pop) begin
      cnt <= cnt_m1;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
  assert_push_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cnt == $past(cnt) + CNT_ONE));
endmodule

// File: rtl/bcs_branch_seq.sv
module bcs_branch_seq
  import bcs_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int RS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [7:0]        opcode,
  input  logic [3:0]        src_sel,
  input  logic [15:0]       offset,
  input  logic [31:0]       imm,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic              is_wide,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              br_taken,
  output logic              prog_done,
  output logic              helper_req,
  output logic              helper_by_type,
  output logic [31:0]       helper_id,
  output logic              fault
);
  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

  logic [2:0] cls;
  logic [3:0] code;
  logic       xsel, narrow;
  assign cls    = opcode[2:0];
  assign code   = opcode[7:4];
  assign xsel   = opcode[3];
  assign narrow = (cls == CLS_J32);

  logic [DATA_W-1:0] opnd_b, off_x, imm_x;
  assign opnd_b = xsel ? src_val : sx32(imm);
  assign off_x  = sx16(offset);
  assign imm_x  = sx32(imm);

  logic cond_taken, cond_ok;
  bcs_cond_eval u_cond (
    .code    (code),
    .narrow  (narrow),
    .dst_val (dst_val),
    .opnd_b  (opnd_b),
    .hit     (cond_taken),
    .legal   (cond_ok)
  );

  // R5: sequential successor and the two displacement targets
  logic [PC_W-1:0] seq_pc, off_tgt, imm_tgt;
  assign seq_pc  = cur_pc + (is_wide ? STEP_TWO : STEP_ONE);
  assign off_tgt = seq_pc + off_x[PC_W-1:0];
  assign imm_tgt = seq_pc + imm_x[PC_W-1:0];

  op_kind_e kind;
  always_comb begin
    kind = K_BAD;
    if (cls == CLS_J64 || cls == CLS_J32) begin
      case (code)
        CODE_JA:   if (!xsel) kind = K_JA;
        CODE_CALL: if (cls == CLS_J64 && !xsel) begin
                     if (src_sel == 4'd0 || src_sel == 4'd2) kind = K_HELPER;
                     else if (src_sel == 4'd1)               kind = K_LCALL;
                   end
        CODE_EXIT: if (cls == CLS_J64 && !xsel && src_sel == 4'd0) kind = K_EXIT;
        default:   if (cond_ok) kind = K_COND;
      endcase
    end
  end

  logic [PC_W-1:0] rs_top;
  logic            rs_full, rs_empty;
  logic            ev_push, ev_pop, ev_overflow;
  assign ev_push     = in_valid && kind == K_LCALL && !rs_full;
  assign ev_pop      = in_valid && kind == K_EXIT && !rs_empty;
  assign ev_overflow = in_valid && kind == K_LCALL && rs_full;

  bcs_ret_stack #(.W(PC_W), .DEPTH(RS_DEPTH)) u_rs (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ev_push),
    .pop     (ev_pop),
    .push_pc (seq_pc),
    .top_pc  (rs_top),
    .full    (rs_full),
    .empty   (rs_empty)
  );

  logic [PC_W-1:0] d_pc;
  logic            d_tk, d_done, d_hreq, d_htype, d_fault;
  always_comb begin
    d_pc = cur_pc; d_tk = 1'b0; d_done = 1'b0;
    d_hreq = 1'b0; d_htype = 1'b0; d_fault = 1'b0;
    case (kind)
      K_COND:   begin d_tk = cond_taken; d_pc = cond_taken ? off_tgt : seq_pc; end
      K_JA:     begin d_tk = 1'b1; d_pc = narrow ? imm_tgt : off_tgt; end
      K_HELPER: begin d_hreq = 1'b1; d_htype = (src_sel == 4'd2); d_pc = seq_pc; end
      K_LCALL:  if (rs_full) d_fault = 1'b1;
                else begin d_tk = 1'b1; d_pc = imm_tgt; end
      K_EXIT:   if (rs_empty) d_done = 1'b1;
                else begin d_tk = 1'b1; d_pc = rs_top; end
      default:  d_fault = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; next_pc <= '0; br_taken <= 1'b0; prog_done <= 1'b0;
      helper_req <= 1'b0; helper_by_type <= 1'b0; helper_id <= '0; fault <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      br_taken       <= in_valid && d_tk;
      prog_done      <= in_valid && d_done;
      helper_req     <= in_valid && d_hreq;
      helper_by_type <= in_valid && d_htype;
      fault          <= in_valid && d_fault;
      if (in_valid) begin
        next_pc   <= d_pc;
        helper_id <= d_hreq ? imm : 32'd0;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_fault_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!br_taken && !prog_done && !helper_req));
  assert_helper_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    helper_req |-> !br_taken);
  assert_overflow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (fault && next_pc == $past(cur_pc)));
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == K_EXIT && rs_empty) |=> (prog_done && next_pc == $past(cur_pc)));
endmodule

// File: tb/bcs_branch_seq_test.sv
module bcs_branch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [7:0]  opcode = '0;
  logic [3:0]  src_sel = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic        is_wide = 1'b0;
  logic        out_valid, br_taken, prog_done, helper_req, helper_by_type, fault;
  logic [31:0] next_pc, helper_id;

  always #2 clk = ~clk;  // 250 MHz

  bcs_branch_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc), .opcode(opcode),
    .src_sel(src_sel), .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .is_wide(is_wide), .out_valid(out_valid), .next_pc(next_pc), .br_taken(br_taken),
    .prog_done(prog_done), .helper_req(helper_req), .helper_by_type(helper_by_type),
    .helper_id(helper_id), .fault(fault)
  );

  typedef struct packed {
    logic [31:0] npc;
    logic tk, dn, hr, ht, ft;
    logic [31:0] hid;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [31:0] model_rs[$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  function automatic logic [7:0] op(input logic [3:0] cd, input logic x, input logic [2:0] cl);
    return {cd, x, cl};
  endfunction

  task automatic issue(input logic [31:0] pc, input logic [7:0] o, input logic [3:0] sr,
                       input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] dv, input logic [63:0] sv,
                       input logic wide, input string tag);
    exp_t e;
    logic [31:0] seq, off32;
    logic [63:0] b, ua, ub;
    longint sa, sb;
    logic [2:0] cl;
    logic [3:0] cd;
    logic x, t;
    @(negedge clk);
    cur_pc = pc; opcode = o; src_sel = sr; offset = off; imm = im;
    dst_val = dv; src_val = sv; is_wide = wide; in_valid = 1'b1;
    e = '0; e.npc = pc;
    cl = o[2:0]; cd = o[7:4]; x = o[3];
    seq = pc + (wide ? 32'd2 : 32'd1);
    off32 = {{16{off[15]}}, off};
    b = x ? sv : {{32{im[31]}}, im};
    if (cl == 3'h6) begin
      ua = {32'b0, dv[31:0]}; ub = {32'b0, b[31:0]};
      sa = $signed(dv[31:0]); sb = $signed(b[31:0]);
    end else begin
      ua = dv; ub = b; sa = $signed(dv); sb = $signed(b);
    end
    if (cl != 3'h5 && cl != 3'h6) e.ft = 1;
    else if (cd == 4'h0) begin
      if (x) e.ft = 1;
      else begin e.tk = 1; e.npc = seq + ((cl == 3'h5) ? off32 : im); end
    end else if (cd == 4'h8) begin
      if (cl != 3'h5 || x) e.ft = 1;
      else if (sr == 0 || sr == 2) begin e.hr = 1; e.ht = (sr == 2); e.hid = im; e.npc = seq; end
      else if (sr == 1) begin
        if (model_rs.size() == 8) e.ft = 1;
        else begin model_rs.push_back(seq); e.tk = 1; e.npc = seq + im; end
      end else e.ft = 1;
    end else if (cd == 4'h9) begin
      if (cl != 3'h5 || x || sr != 0) e.ft = 1;
      else if (model_rs.size() == 0) e.dn = 1;
      else begin e.tk = 1; e.npc = model_rs.pop_back(); end
    end else if (cd == 4'he || cd == 4'hf) e.ft = 1;
    else begin
      case (cd)
        4'h1: t = (ua == ub);
        4'h2: t = (ua > ub);
        4'h3: t = (ua >= ub);
        4'h4: t = ((ua & ub) != 0);
        4'h5: t = (ua != ub);
        4'h6: t = (sa > sb);
        4'h7: t = (sa >= sb);
        4'ha: t = (ua < ub);
        4'hb: t = (ua <= ub);
        4'hc: t = (sa < sb);
        default: t = (sa <= sb);
      endcase
      e.tk = t; e.npc = t ? seq + off32 : seq;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t g, e;
    string tg;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        g = {next_pc, br_taken, prog_done, helper_req, helper_by_type, fault, helper_id};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected result got=%h expected=none", g);
        end else begin
          e = exp_q.pop_front(); tg = tag_q.pop_front();
          if (g !== e) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", tg, g, e);
          end
        end
      end
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [3:0] CODES [11] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
                                         4'ha, 4'hb, 4'hc, 4'hd};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({out_valid, br_taken, prog_done, helper_req, helper_by_type, fault} !== 6'b0 ||
        next_pc !== 32'd0 || helper_id !== 32'd0) begin
      errors++;
      $display("FAIL R1: reset outputs got=%b pc=%h expected=0",
               {out_valid, br_taken, prog_done, helper_req, helper_by_type, fault}, next_pc);
    end

    // R3 / R5: basic equal compares, normal and wide
    issue(32'd100, op(4'h1, 1, 3'h5), 0, 16'd5, 0, 64'd7, 64'd7, 0, "R3 jeq reg");
    issue(32'd100, op(4'h1, 1, 3'h5), 0, 16'd5, 0, 64'd7, 64'd7, 1, "R5 wide successor");
    issue(32'd100, op(4'h5, 1, 3'h5), 0, 16'd5, 0, 64'd7, 64'd7, 1, "R5 wide not taken");
    issue(32'hFFFF_FFFF, op(4'h1, 0, 3'h5), 0, 16'hFFFE, 32'hFFFF_FFFF, '1, 0, 0, "R3 imm sign extend");
    issue(32'd10, op(4'h4, 1, 3'h5), 0, 16'd3, 0, 64'hA, 64'h5, 0, "R3 and-test clear");
    issue(32'd10, op(4'h4, 1, 3'h5), 0, 16'd3, 0, 64'hA, 64'h2, 0, "R3 and-test set");
    // R3 / R4: every condition, both widths, sign and width discriminating pairs
    foreach (CODES[i]) begin
      issue(32'd1000, op(CODES[i], 1, 3'h5), 0, 16'd20, 0, '1, 64'd1, 0, "R3 sign pair 64");
      issue(32'd1000, op(CODES[i], 1, 3'h6), 0, 16'd20, 0, 64'h1_8000_0000, 64'd1, 0, "R4 low-half pair");
      issue(32'd1000, op(CODES[i], 1, 3'h5), 0, 16'hFFF0, 0, 64'h1_8000_0000, 64'd1, 0, "R3 wide pair 64");
      issue(32'd1000, op(CODES[i], 0, 3'h6), 0, 16'd9, 32'd5, 64'h7_0000_0005, 0, 0, "R4 imm low half");
    end
    // R6: unconditional jumps
    issue(32'd200, op(4'h0, 0, 3'h5), 0, 16'hFFFD, 32'd50, 0, 0, 0, "R6 offset jump");
    issue(32'd200, op(4'h0, 0, 3'h6), 0, 16'd7, 32'd1000, 0, 0, 0, "R6 imm jump");
    // R7: helper calls
    issue(32'd300, op(4'h8, 0, 3'h5), 4'd0, 0, 32'h1234, 0, 0, 0, "R7 static helper");
    issue(32'd300, op(4'h8, 0, 3'h5), 4'd2, 0, 32'd99, 0, 0, 1, "R7 typed helper");
    // R8 / R9 / R10: nested calls and returns
    issue(32'd400, op(4'h8, 0, 3'h5), 4'd1, 0, 32'd10, 0, 0, 0, "R8 call one");
    issue(32'd411, op(4'h8, 0, 3'h5), 4'd1, 0, 32'd20, 0, 0, 1, "R8 call two wide");
    issue(32'd433, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R9 return inner");
    issue(32'd500, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R9 return outer");
    issue(32'd600, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R10 exit top level");
    // R11: fill the stack, overflow, then drain
    for (int k = 0; k < 8; k++)
      issue(32'd700 + 32'(k * 16), op(4'h8, 0, 3'h5), 4'd1, 0, 32'd3, 0, 0, 0, "R8 fill");
    issue(32'd900, op(4'h8, 0, 3'h5), 4'd1, 0, 32'd3, 0, 0, 0, "R11 overflow fault");
    for (int k = 0; k < 8; k++)
      issue(32'd950, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R11 drain intact");
    issue(32'd960, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R10 drained exit");
    // R12: illegal forms between a call and its exit
    issue(32'd40, op(4'h8, 0, 3'h5), 4'd1, 0, 32'd4, 0, 0, 0, "R8 guard call");
    issue(32'd50, op(4'h1, 1, 3'h4), 0, 16'd1, 0, 0, 0, 0, "R12 wrong class");
    issue(32'd51, op(4'he, 1, 3'h5), 0, 16'd1, 0, 0, 0, 0, "R12 code e");
    issue(32'd52, op(4'hf, 0, 3'h6), 0, 16'd1, 0, 0, 0, 0, "R12 code f");
    issue(32'd53, op(4'h0, 1, 3'h5), 0, 16'd1, 0, 0, 0, 0, "R12 jump reg form");
    issue(32'd54, op(4'h8, 0, 3'h6), 4'd1, 0, 32'd1, 0, 0, 0, "R12 call narrow class");
    issue(32'd55, op(4'h8, 0, 3'h5), 4'd3, 0, 32'd1, 0, 0, 0, "R12 call subtype 3");
    issue(32'd56, op(4'h9, 1, 3'h5), 0, 0, 0, 0, 0, 0, "R12 exit reg form");
    issue(32'd57, op(4'h9, 0, 3'h5), 4'd1, 0, 0, 0, 0, 0, "R12 exit nonzero src");
    issue(32'd58, op(4'h9, 0, 3'h5), 0, 0, 0, 0, 0, 0, "R12 stack untouched");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle out_valid got=%b expected=0", out_valid);
    end
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: missing results got=%0d pending expected=0", exp_q.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule